// File: doc/BRIEF.md
# Vector Register Gather Decoder and Legality Checker

This block looks at a 32-bit instruction word and the active vector configuration and decides whether the word is one of the four register-gather encodings. The four encodings are: vector-indexed, scalar-indexed, immediate-indexed, and vector-indexed with fixed 16-bit indices. For a recognised word it reports the form and how many vector registers each operand group spans. It also raises one illegal-instruction flag when the encoding, the configuration or the register choice breaks a rule.

The configuration arrives as log2 of the element width in bytes (0 for 8-bit up to 3 for 64-bit) and as a signed log2 of the group multiplier (-3 to 3). A vector-enable flag comes with them. The 16-bit-index form uses a fixed 16-bit index element. Its index group therefore gets its own multiplier, and alignment and overlap must be judged between groups of different sizes. All outputs are registered, so each result appears one clock after its inputs.

Top module: `gather_decode`

## Requirements
- R1: With major opcode 1010111 in bits 6:0, the code on `form_o` is set by bits 31:26 and 14:12. It is 1 for 001100/000 (vector index), 2 for 001100/100 (scalar index), 3 for 001100/011 (immediate index) and 4 for 001110/000 (16-bit vector index). Any other word gives 0. Bit 25 does not affect the form.
- R2: `illegal_o` is 1 when `form_o` is 0 or when `vec_en_i` was low. The form is still reported when `vec_en_i` is low.
- R3: An element-width code above 3, or a multiplier code of 3'b100, makes every form illegal.
- R4: For form 4 the index multiplier is log2 EMUL = 1 − `vsew_i` + `vlmul_i`. A value outside −3..3 is illegal.
- R5: When the result is legal, `rd_grp_o` and `rs2_grp_o` equal 2^max(lmul,0). `rs1_grp_o` is that same size for form 1, 2^max(emul,0) for form 4, and 0 for forms 2 and 3. When the result is illegal, all three are 0.
- R6: Each register number (rd in bits 11:7, rs2 in bits 24:20, and for forms 1 and 4 rs1 in bits 19:15) must be a multiple of its own group size, or the word is illegal.
- R7: rd equal to rs2, or rd equal to rs1 in forms 1 and 4, is illegal.
- R8: The destination group must not overlap the rs2 group, nor the rs1 group in forms 1 and 4. Each group spans [reg, reg+size).
- R9: With bit 25 clear (masked), rd = 0 is illegal.
- R10: Reset (synchronous, active high) gives form 0, group sizes 0 and `illegal_o` = 1. Otherwise the outputs reflect the inputs one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 32 | Instruction word |
| vsew_i | input | 3 | log2 of element width in bytes |
| vlmul_i | input | 3 | Signed log2 of group multiplier |
| vec_en_i | input | 1 | Vector unit enabled |
| form_o | output | 3 | Decoded form code |
| rd_grp_o | output | 4 | Destination group size in registers |
| rs1_grp_o | output | 4 | Index group size (0 if not a vector) |
| rs2_grp_o | output | 4 | Source group size |
| illegal_o | output | 1 | Illegal-instruction flag |

## Verification
A 16-bit-index word can fail the EMUL range test and the alignment or overlap tests at the same time. A masked word can fail the v0 rule while its groups also collide. The sweep provokes this by crossing every element width and multiplier code with both mask settings and with register numbers that mix aligned, misaligned and adjacent values. Each result is judged against a bench model. The model reports the first rule broken, so a missing or wrongly merged term is reported with the requirement it belongs to.

// File: rtl/gather_pkg.sv
package gather_pkg;
  typedef enum logic [2:0] {
    FORM_NONE = 3'd0,
    FORM_VV   = 3'd1,
    FORM_VX   = 3'd2,
    FORM_VI   = 3'd3,
    FORM_VV16 = 3'd4
  } form_e;

  localparam logic [6:0] OPC_VECTOR  = 7'b1010111;
  localparam logic [5:0] F6_GATHER   = 6'b001100;
  localparam logic [5:0] F6_GATHER16 = 6'b001110;
  localparam logic [2:0] F3_VV       = 3'b000;
  localparam logic [2:0] F3_VX       = 3'b100;
  localparam logic [2:0] F3_VI       = 3'b011;

  // registers spanned by a group whose signed log2 multiplier is l
  function automatic logic [4:0] grp_size(input logic signed [4:0] l);
    if (l <= 0) grp_size = 5'd1;
    else        grp_size = 5'd1 << l;
  endfunction
endpackage

// File: rtl/gather_field_decode.sv
module gather_field_decode
  import gather_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [31:0]      insn,
  output form_e            form,
  output logic [REG_W-1:0] rd,
  output logic [REG_W-1:0] rs1,
  output logic [REG_W-1:0] rs2,
  output logic             unmasked
);
  logic [5:0] f6;
  logic [2:0] f3;
  logic       opc_hit;

  always_comb begin
    f6       = insn[31:26];
    f3       = insn[14:12];
    unmasked = insn[25];
    rs2      = insn[20 +: REG_W];
    rs1      = insn[15 +: REG_W];
    rd       = insn[7 +: REG_W];
    opc_hit  = (insn[6:0] == OPC_VECTOR);
    form     = FORM_NONE;
    if (opc_hit && f6 == F6_GATHER) begin
      unique case (f3)
        F3_VV:   form = FORM_VV;
        F3_VX:   form = FORM_VX;
        F3_VI:   form = FORM_VI;
        default: form = FORM_NONE;
      endcase
    end else if (opc_hit && f6 == F6_GATHER16 && f3 == F3_VV) begin
      form = FORM_VV16;
    end
  end
endmodule

// File: rtl/gather_group_calc.sv
module gather_group_calc
  import gather_pkg::*;
#(
  parameter int MAX_SEW_LOG2  = 3,
  parameter int MAX_LMUL_LOG2 = 3,
  parameter int IDX_SEW_LOG2  = 1,
  parameter int SZ_W          = 5
) (
  input  form_e            form,
  input  logic [2:0]       vsew,
  input  logic [2:0]       vlmul,
  output logic             cfg_ok,
  output logic             emul_ok,
  output logic [SZ_W-1:0]  dst_n,
  output logic [SZ_W-1:0]  idx_n
);
  localparam logic [2:0] LMUL_RSVD = 3'b100;
  localparam int         EMUL_MIN  = -MAX_LMUL_LOG2;
  localparam int         EMUL_MAX  = MAX_LMUL_LOG2;

  logic signed [4:0] lmul_x;
  logic signed [4:0] emul_x;
  logic [4:0]        dst_raw;
  logic [4:0]        idx_raw;

  always_comb begin
    lmul_x  = {{2{vlmul[2]}}, vlmul};
    emul_x  = 5'(IDX_SEW_LOG2) - $signed({2'b00, vsew}) + lmul_x;
    cfg_ok  = (int'(vsew) <= MAX_SEW_LOG2) && (vlmul != LMUL_RSVD);
    emul_ok = (int'(emul_x) >= EMUL_MIN) && (int'(emul_x) <= EMUL_MAX);
    dst_raw = grp_size(lmul_x);
    case (form)
      FORM_VV:   idx_raw = dst_raw;
      FORM_VV16: idx_raw = grp_size(emul_x);
      default:   idx_raw = 5'd0;
    endcase
    dst_n = SZ_W'(dst_raw);
    idx_n = SZ_W'(idx_raw);
  end
endmodule

// File: rtl/gather_legal_check.sv
module gather_legal_check #(
  parameter int REG_W = 5,
  parameter int SZ_W  = 5
) (
  input  logic [REG_W-1:0] rd,
  input  logic [REG_W-1:0] rs1,
  input  logic [REG_W-1:0] rs2,
  input  logic             unmasked,
  input  logic [SZ_W-1:0]  dst_n,
  input  logic [SZ_W-1:0]  idx_n,
  output logic             align_bad,
  output logic             same_bad,
  output logic             ovl_bad,
  output logic             mask_bad
);
  localparam int SUM_W = ((REG_W > SZ_W) ? REG_W : SZ_W) + 1;

  function automatic logic ranges_meet(input logic [REG_W-1:0] a, input logic [SZ_W-1:0] na,
                                       input logic [REG_W-1:0] b, input logic [SZ_W-1:0] nb);
    logic [SUM_W-1:0] a_lo, b_lo, a_hi, b_hi;
    a_lo = SUM_W'(a);
    b_lo = SUM_W'(b);
    a_hi = a_lo + SUM_W'(na);
    b_hi = b_lo + SUM_W'(nb);
    ranges_meet = (na != '0) && (nb != '0) && (a_lo < b_hi) && (b_lo < a_hi);
  endfunction

  logic             idx_vec;
  logic [REG_W-1:0] dst_mask;
  logic [REG_W-1:0] idx_mask;

  always_comb begin
    idx_vec   = (idx_n != '0);
    dst_mask  = REG_W'(dst_n - SZ_W'(1));
    idx_mask  = idx_vec ? REG_W'(idx_n - SZ_W'(1)) : '0;
    align_bad = ((rd & dst_mask) != '0) || ((rs2 & dst_mask) != '0) ||
                ((rs1 & idx_mask) != '0);
    same_bad  = (rd == rs2) || (idx_vec && rd == rs1);
    ovl_bad   = ranges_meet(rd, dst_n, rs2, dst_n) || ranges_meet(rd, dst_n, rs1, idx_n);
    mask_bad  = !unmasked && (rd == '0);
  end
endmodule

// File: rtl/gather_decode.sv
module gather_decode
  import gather_pkg::*;
#(
  parameter int MAX_SEW_LOG2  = 3,
  parameter int MAX_LMUL_LOG2 = 3,
  parameter int IDX_SEW_LOG2  = 1,
  parameter int NREG          = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [31:0]            insn_i,
  input  logic [2:0]             vsew_i,
  input  logic [2:0]             vlmul_i,
  input  logic                   vec_en_i,
  output logic [2:0]             form_o,
  output logic [MAX_LMUL_LOG2:0] rd_grp_o,
  output logic [MAX_LMUL_LOG2:0] rs1_grp_o,
  output logic [MAX_LMUL_LOG2:0] rs2_grp_o,
  output logic                   illegal_o
);
  localparam int REG_W = $clog2(NREG);
  localparam int GRP_W = MAX_LMUL_LOG2 + 1;
  localparam int SZ_W  = GRP_W + 1;

  form_e            form;
  logic [REG_W-1:0] rd, rs1, rs2;
  logic             unmasked;
  logic             cfg_ok, emul_ok;
  logic [SZ_W-1:0]  dst_n, idx_n;
  logic             align_bad, same_bad, ovl_bad, mask_bad;
  logic             bad;

  gather_field_decode #(.REG_W(REG_W)) u_fields (
    .insn(insn_i), .form(form), .rd(rd), .rs1(rs1), .rs2(rs2), .unmasked(unmasked)
  );

  gather_group_calc #(
    .MAX_SEW_LOG2(MAX_SEW_LOG2), .MAX_LMUL_LOG2(MAX_LMUL_LOG2),
    .IDX_SEW_LOG2(IDX_SEW_LOG2), .SZ_W(SZ_W)
  ) u_groups (
    .form(form), .vsew(vsew_i), .vlmul(vlmul_i),
    .cfg_ok(cfg_ok), .emul_ok(emul_ok), .dst_n(dst_n), .idx_n(idx_n)
  );

  gather_legal_check #(.REG_W(REG_W), .SZ_W(SZ_W)) u_rules (
    .rd(rd), .rs1(rs1), .rs2(rs2), .unmasked(unmasked),
    .dst_n(dst_n), .idx_n(idx_n),
    .align_bad(align_bad), .same_bad(same_bad), .ovl_bad(ovl_bad), .mask_bad(mask_bad)
  );

  always_comb begin
    bad = !vec_en_i || (form == FORM_NONE) || !cfg_ok ||
          ((form == FORM_VV16) && !emul_ok) ||
          align_bad || same_bad || ovl_bad || mask_bad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      form_o    <= FORM_NONE;
      rd_grp_o  <= '0;
      rs1_grp_o <= '0;
      rs2_grp_o <= '0;
      illegal_o <= 1'b1;
    end else begin
      form_o    <= form;
      illegal_o <= bad;
      rd_grp_o  <= bad ? '0 : GRP_W'(dst_n);
      rs2_grp_o <= bad ? '0 : GRP_W'(dst_n);
      rs1_grp_o <= bad ? '0 : GRP_W'(idx_n);
    end
  end

  // R2: no matching form never yields a legal result
  p_nomatch_illegal_r2: assert property (@(posedge clk) disable iff (rst)
    (form_o == FORM_NONE) |-> illegal_o);

  // R2: disabled vector unit in the previous cycle forces illegal
  p_disabled_illegal_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(vec_en_i) |-> illegal_o);

  // R5: legal groups are powers of two, source equals destination
  p_grp_pow2_r5: assert property (@(posedge clk) disable iff (rst)
    !illegal_o |-> ($onehot(rd_grp_o) && rs2_grp_o == rd_grp_o));

  // R6: a legal destination is aligned to its group
  p_rd_aligned_r6: assert property (@(posedge clk) disable iff (rst)
    !illegal_o |-> (($past(insn_i[11:7]) & 5'(rd_grp_o - 1'b1)) == 5'd0));

  // R7: a legal destination differs from the source register
  p_rd_ne_rs2_r7: assert property (@(posedge clk) disable iff (rst)
    !illegal_o |-> ($past(insn_i[11:7]) != $past(insn_i[24:20])));

  // R9: masked and legal never writes v0
  p_mask_v0_r9: assert property (@(posedge clk) disable iff (rst)
    (!illegal_o && !$past(insn_i[25])) |-> ($past(insn_i[11:7]) != 5'd0));
endmodule

// File: tb/tb_gather_decode.sv
`timescale 1ns/1ps
module tb_gather_decode;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] insn_i;
  logic [2:0]  vsew_i, vlmul_i;
  logic        vec_en_i;
  logic [2:0]  form_o;
  logic [3:0]  rd_grp_o, rs1_grp_o, rs2_grp_o;
  logic        illegal_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  gather_decode dut (
    .clk(clk), .rst(rst), .insn_i(insn_i), .vsew_i(vsew_i), .vlmul_i(vlmul_i),
    .vec_en_i(vec_en_i), .form_o(form_o), .rd_grp_o(rd_grp_o), .rs1_grp_o(rs1_grp_o),
    .rs2_grp_o(rs2_grp_o), .illegal_o(illegal_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] mk(input int f, input int vm, input int rd, input int r1, input int r2);
    logic [5:0] f6;
    logic [2:0] f3;
    f6 = (f == 4) ? 6'b001110 : 6'b001100;
    case (f)
      2: f3 = 3'b100;
      3: f3 = 3'b011;
      default: f3 = 3'b000;
    endcase
    mk = {f6, 1'(vm), 5'(r2), 5'(r1), f3, 5'(rd), 7'b1010111};
  endfunction

  function automatic bit meet(input int a, input int na, input int b, input int nb);
    meet = (na > 0) && (nb > 0) && (a < b + nb) && (b < a + na);
  endfunction

  task automatic model(input int f, input int sew, input int lm, input int vm, input int rd,
                       input int r1, input int r2, input int en,
                       output int e_ill, output int e_d, output int e_1, output string why);
    int dn, idx, em;
    em  = 1 - sew + lm;
    why = "";
    dn  = (lm > 0) ? (1 << lm) : 1;
    idx = (f == 1) ? dn : (f == 4) ? ((em > 0) ? (1 << em) : 1) : 0;
    if (!en || f == 0) why = "R2";
    else if (sew > 3 || lm == -4) why = "R3";
    else if (f == 4 && (em < -3 || em > 3)) why = "R4";
    else if ((rd % dn) != 0 || (r2 % dn) != 0 || (idx > 0 && (r1 % idx) != 0)) why = "R6";
    else if (rd == r2 || (idx > 0 && rd == r1)) why = "R7";
    else if (meet(rd, dn, r2, dn) || meet(rd, dn, r1, idx)) why = "R8";
    else if (vm == 0 && rd == 0) why = "R9";
    e_ill = (why != "") ? 1 : 0;
    e_d   = e_ill ? 0 : dn;
    e_1   = e_ill ? 0 : idx;
  endtask

  task automatic judge(input int e_form, input int e_ill, input int e_d, input int e_1, input string why);
    checks = checks + 1;
    if (int'(form_o) != e_form) begin
      fails = fails + 1;
      $display("FAIL R1 form: actual %0d expected %0d", form_o, e_form);
    end else if (int'(illegal_o) != e_ill) begin
      fails = fails + 1;
      $display("FAIL %s illegal: actual %0d expected %0d", (why == "") ? "R5" : why, illegal_o, e_ill);
    end else if (int'(rd_grp_o) != e_d || int'(rs2_grp_o) != e_d || int'(rs1_grp_o) != e_1) begin
      fails = fails + 1;
      $display("FAIL R5 groups: actual %0d/%0d/%0d expected %0d/%0d/%0d",
               rd_grp_o, rs1_grp_o, rs2_grp_o, e_d, e_1, e_d);
    end
  endtask

  task automatic run(input int f, input int sew, input int lm, input int vm, input int rd,
                     input int r1, input int r2, input int en);
    int ei, ed, e1;
    string why;
    insn_i   = mk(f, vm, rd, r1, r2);
    vsew_i   = 3'(sew);
    vlmul_i  = 3'(lm);
    vec_en_i = 1'(en);
    model(f, sew, lm, vm, rd, r1, r2, en, ei, ed, e1, why);
    @(posedge clk); #1;
    judge(f, ei, ed, e1, why);
  endtask

  task automatic raw(input logic [31:0] w, input string tag);
    insn_i = w; vsew_i = 3'd0; vlmul_i = 3'd0; vec_en_i = 1'b1;
    @(posedge clk); #1;
    checks = checks + 1;
    if (form_o != 3'd0 || illegal_o != 1'b1) begin
      fails = fails + 1;
      $display("FAIL %s nonmatch: actual form %0d ill %0d expected form 0 ill 1", tag, form_o, illegal_o);
    end
  endtask

  initial begin
    automatic int regs[6] = '{0, 1, 2, 4, 8, 12};
    rst = 1'b1; insn_i = '0; vsew_i = '0; vlmul_i = '0; vec_en_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset values
    checks = checks + 1;
    if (form_o != 3'd0 || illegal_o != 1'b1 || rd_grp_o != 0 || rs1_grp_o != 0 || rs2_grp_o != 0) begin
      fails = fails + 1;
      $display("FAIL R10 reset: actual form %0d ill %0d expected form 0 ill 1", form_o, illegal_o);
    end
    rst = 1'b0;
    // R10: a legal word applied between edges does not show before the next edge
    insn_i = mk(1, 1, 4, 8, 12); vsew_i = 3'd2; vlmul_i = 3'd2; vec_en_i = 1'b1;
    #1;
    checks = checks + 1;
    if (illegal_o != 1'b1) begin
      fails = fails + 1;
      $display("FAIL R10 latency: actual ill %0d expected 1", illegal_o);
    end
    @(posedge clk); #1;
    judge(1, 0, 4, 4, "R10");

    // R2: encodings that match no form
    raw(mk(1, 1, 4, 8, 12) ^ 32'h1, "R2 opcode");
    raw({6'b001101, 1'b1, 5'd8, 5'd4, 3'b000, 5'd2, 7'b1010111}, "R2 funct6");
    raw({6'b001100, 1'b1, 5'd8, 5'd4, 3'b001, 5'd2, 7'b1010111}, "R2 funct3");
    raw({6'b001110, 1'b1, 5'd8, 5'd4, 3'b100, 5'd2, 7'b1010111}, "R2 wide scalar");
    // R2: disabled unit still reports the form
    run(1, 0, 0, 1, 2, 4, 6, 0);
    run(4, 0, 0, 1, 2, 4, 6, 0);
    // R4: 64-bit elements with 1/8 multiplier gives emul -5; 8-bit with x8 gives 4
    run(4, 3, -3, 1, 2, 4, 6, 1);
    run(4, 0, 3, 1, 0, 8, 16, 1);
    // R4: 8-bit with x4 gives emul 3, legal with 8-register index group
    run(4, 0, 2, 1, 4, 16, 8, 1);

    // R1 R3 R5 R6 R7 R8 R9: sweep of forms, configurations, mask and registers
    for (int f = 1; f <= 4; f++)
      for (int sew = 0; sew <= 4; sew++)
        for (int lm = -4; lm <= 3; lm++)
          for (int vm = 0; vm <= 1; vm++)
            for (int a = 0; a < 6; a++)
              for (int b = 0; b < 6; b++)
                for (int c = 0; c < 6; c++)
                  run(f, sew, lm, vm, regs[a], regs[b], regs[c], 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule